// File: doc/BRIEF.md
# Status Register Transfer Unit

This unit carries out the two instructions that move program status between the status registers and the general register file of a 32-bit core. The read form copies a status word into a general register. The write form loads a status register from a general register. A flags-only variant of the write changes just the four condition flags, and it can take its operand from a rotated 8-bit immediate instead of a register.

The unit holds the current status word and one saved status word for each privileged mode. The pipeline presents an instruction word together with a valid strobe. A separate selector input chooses whether the current word or the saved word of the present mode is the target. The unit drives a combinational read address into the register file and receives the data back in the same cycle. One clock later it reports a write-back to the register file, the updated status registers, a done pulse, and an error flag for encodings it rejects.

Top module: `psr_xfer_unit`

## Requirements
- R1: During reset, and until the first accepted instruction, the current status word is 0x000000D3 (supervisor mode 5'b10011, interrupt bits 7 and 6 set). Every saved bank reads zero. `done`, `err` and `rf_wr_en` are low.
- R2: Bits [21:19] = 3'b001 decode as a read and 3'b101 as a write. For a write, bits [18:16] = 3'b000 mean a full write and 3'b001 mean a flags-only write. Every other combination raises `err`, writes no register and leaves both status registers unchanged.
- R3: A read writes the selected 32-bit status word, taken before the instruction's effect, into the register whose index is in bits [15:12].
- R4: A full write, outside user mode, replaces the whole target word with the register addressed by bits [3:0].
- R5: A flags-only write copies operand bits [31:28] into target bits [31:28] (N, Z, C, V) and keeps target bits [27:0].
- R6: When bit 25 is set, the operand of a flags-only write is the 8-bit field [7:0] rotated right by twice the value in [11:8]. When bit 25 is clear, the operand is the register addressed by [3:0].
- R7: With `target_saved` high, the target is the saved bank of the current mode. Mode codes 5'b10001, 10010, 10011, 10111 and 11011 each own a separate bank.
- R8: In user mode (5'b10000), a full write to the current word changes only bits [31:28].
- R9: A saved-target access in a mode without a bank (user, system 5'b11111, or any other code) raises `err`, writes no register and changes no status word.
- R10: Results appear on the clock edge after `in_valid`. `done` is high for exactly the cycles that follow an accepted strobe. `err` only appears together with `done`.
- R11: `spsr_q` shows the saved bank of the current mode, or zero in a mode without a bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| target_saved | input | 1 | 1 selects the saved status word, 0 the current one |
| rf_rd_idx | output | 4 | Register file read address (bits [3:0]) |
| rf_rd_data | input | 32 | Register file read data, same cycle |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write address |
| rf_wr_data | output | 32 | Register file write data |
| cpsr_q | output | 32 | Current status word |
| spsr_q | output | 32 | Saved status word of the current mode |
| done | output | 1 | One pulse per accepted strobe |
| err | output | 1 | Rejected instruction |

## Verification
Two functions can fall in the same cycle. A full write that changes the mode field can be followed directly by an access to the saved bank. A status write can also sit right next to a read of the same word. The bench issues these as back-to-back strobes, with no idle cycle between them. It checks that the saved access uses the bank of the newly written mode, and that a read sees the word as it stood before that read's own edge. Each result is compared with a model that tracks the status words, the banks and the register file in step with the strobes.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int unsigned PSR_W     = 32;
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned N_BANKS   = 5;
  localparam int unsigned BANK_IW   = $clog2(N_BANKS);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

  typedef enum logic [1:0] {
    XF_NONE  = 2'd0,
    XF_READ  = 2'd1,
    XF_FULL  = 2'd2,
    XF_FLAGS = 2'd3
  } xfer_op_e;

  typedef struct packed {
    logic               hit;
    logic [BANK_IW-1:0] idx;
  } bank_sel_t;

  // Map a mode code onto its saved-status bank.
  function automatic bank_sel_t bank_of(input logic [MODE_W-1:0] m);
    bank_sel_t s;
    s.hit = 1'b1;
    s.idx = '0;
    case (m)
      MODE_FIQ: s.idx = BANK_IW'(0);
      MODE_IRQ: s.idx = BANK_IW'(1);
      MODE_SVC: s.idx = BANK_IW'(2);
      MODE_ABT: s.idx = BANK_IW'(3);
      MODE_UND: s.idx = BANK_IW'(4);
      default:  s.hit = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/psr_decode.sv
module psr_decode
  import psr_pkg::*;
(
  input  logic [31:0] instr,
  output xfer_op_e    op,
  output logic        use_imm,
  output logic [3:0]  rd,
  output logic [3:0]  rm,
  output logic [3:0]  rot,
  output logic [7:0]  imm8
);

  logic [2:0] cls;
  logic [2:0] sub;
  logic       unused_bits;

  assign cls     = instr[21:19];
  assign sub     = instr[18:16];
  assign use_imm = instr[25];
  assign rd      = instr[15:12];
  assign rm      = instr[3:0];
  assign rot     = instr[11:8];
  assign imm8    = instr[7:0];
  assign unused_bits = ^{instr[31:26], instr[24:22]};

  always_comb begin
    op = XF_NONE;
    case (cls)
      3'b001: op = XF_READ;
      3'b101: begin
        if (sub == 3'b000)      op = XF_FULL;
        else if (sub == 3'b001) op = XF_FLAGS;
        else                    op = XF_NONE;
      end
      default: op = XF_NONE;
    endcase
  end

endmodule

// File: rtl/psr_imm_rot.sv
module psr_imm_rot #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  output logic [W-1:0]     val
);

  localparam int unsigned AMT_W = ROT_W + 1;

  logic [W-1:0]   ext;
  logic [2*W-1:0] dbl;
  logic [AMT_W-1:0] amt;
  logic [W-1:0]   unused_hi;

  assign ext = W'(imm);
  assign amt = {rot, 1'b0};
  assign dbl = {ext, ext} >> amt;
  assign val = dbl[W-1:0];
  assign unused_hi = dbl[2*W-1:W];

  // R6: a zero rotate field passes the immediate through untouched.
  always_comb begin
    if (rot == '0) begin
      a_r6_zero_rotate: assert (val == ext);
    end
  end

endmodule

// File: rtl/psr_spsr_bank.sv
module psr_spsr_bank #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] widx,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] ridx,
  output logic [W-1:0]         rdata
);

  localparam int unsigned IW = $clog2(N);

  logic [W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                         mem[g] <= '0;
      else if (we && widx == IW'(g))   mem[g] <= wdata;
    end
  end

  assign rdata = (ridx < IW'(N)) ? mem[ridx] : '0;

  // R7: a bank write never targets a slot that does not exist.
  a_r7_bank_in_range: assert property (@(posedge clk) disable iff (rst)
    we |-> (widx < IW'(N)));

endmodule

// File: rtl/psr_xfer_unit.sv
module psr_xfer_unit
  import psr_pkg::*;
#(
  parameter int unsigned DW    = PSR_W,
  parameter int unsigned RF_AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    instr,
  input  logic             target_saved,
  output logic [RF_AW-1:0] rf_rd_idx,
  input  logic [DW-1:0]    rf_rd_data,
  output logic             rf_wr_en,
  output logic [RF_AW-1:0] rf_wr_idx,
  output logic [DW-1:0]    rf_wr_data,
  output logic [DW-1:0]    cpsr_q,
  output logic [DW-1:0]    spsr_q,
  output logic             done,
  output logic             err
);

  localparam int unsigned FLAG_LSB = DW - 4;

  xfer_op_e    op;
  logic        use_imm;
  logic [3:0]  f_rd, f_rm, f_rot;
  logic [7:0]  f_imm;

  psr_decode u_dec (
    .instr   (instr[31:0]),
    .op      (op),
    .use_imm (use_imm),
    .rd      (f_rd),
    .rm      (f_rm),
    .rot     (f_rot),
    .imm8    (f_imm)
  );

  assign rf_rd_idx = RF_AW'(f_rm);

  logic [DW-1:0] imm_val;

  psr_imm_rot #(.W(DW), .IMM_W(8), .ROT_W(4)) u_rot (
    .imm (f_imm),
    .rot (f_rot),
    .val (imm_val)
  );

  bank_sel_t     cur_bank;
  logic [DW-1:0] bank_rdata;
  logic          bank_we;
  logic [DW-1:0] new_word;

  assign cur_bank = bank_of(cpsr_q[MODE_W-1:0]);

  psr_spsr_bank #(.W(DW), .N(N_BANKS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (bank_we),
    .widx  (cur_bank.idx),
    .wdata (new_word),
    .ridx  (cur_bank.idx),
    .rdata (bank_rdata)
  );

  logic [DW-1:0] sel_word;
  logic [DW-1:0] operand;
  logic          reject;
  logic          in_user;
  logic          wr_accept;
  logic          unused_low;

  assign sel_word   = target_saved ? bank_rdata : cpsr_q;
  assign operand    = use_imm ? imm_val : rf_rd_data;
  assign unused_low = ^operand[FLAG_LSB-1:0];
  assign in_user    = (cpsr_q[MODE_W-1:0] == MODE_USR);
  assign reject     = (op == XF_NONE) || (target_saved && !cur_bank.hit);
  assign wr_accept  = in_valid && !reject && (op == XF_FULL || op == XF_FLAGS);
  assign bank_we    = wr_accept && target_saved;

  always_comb begin
    case (op)
      XF_FULL:
        if (!target_saved && in_user)
          new_word = {rf_rd_data[DW-1:FLAG_LSB], cpsr_q[FLAG_LSB-1:0]};
        else
          new_word = rf_rd_data;
      XF_FLAGS: new_word = {operand[DW-1:FLAG_LSB], sel_word[FLAG_LSB-1:0]};
      default:  new_word = sel_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                             cpsr_q <= DW'(PSR_RESET);
    else if (wr_accept && !target_saved) cpsr_q <= new_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      err        <= 1'b0;
      rf_wr_en   <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
    end else begin
      done     <= in_valid;
      err      <= in_valid && reject;
      rf_wr_en <= in_valid && !reject && (op == XF_READ);
      if (in_valid && op == XF_READ) begin
        rf_wr_idx  <= RF_AW'(f_rd);
        rf_wr_data <= sel_word;
      end
    end
  end

  assign spsr_q = cur_bank.hit ? bank_rdata : '0;

  // R10: every strobe yields done on the next edge.
  a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);
  // R10: no strobe, no result of any kind.
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!done && !err && !rf_wr_en));
  // R2: a rejected instruction writes no register.
  a_r2_err_no_write: assert property (@(posedge clk) disable iff (rst)
    err |-> !rf_wr_en);
  // R3: write-back only happens as the result of a strobe.
  a_r3_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> done);
  // R5: flags-only writes keep the low 28 bits of the current word.
  a_r5_flags_keep_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == XF_FLAGS) |=> (cpsr_q[FLAG_LSB-1:0] == $past(cpsr_q[FLAG_LSB-1:0])));
  // R8: nothing issued in user mode touches the low bits of the current word.
  a_r8_user_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_user) |=> (cpsr_q[FLAG_LSB-1:0] == $past(cpsr_q[FLAG_LSB-1:0])));
  // R9: a saved access without a bank is refused and has no effect.
  a_r9_no_bank_refused: assert property (@(posedge clk) disable iff (rst)
    (in_valid && target_saved && !cur_bank.hit) |=> (err && !rf_wr_en && $stable(cpsr_q)));

endmodule

// File: tb/psr_xfer_unit_test.sv
module psr_xfer_unit_test;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, in_valid, target_saved;
  logic [31:0] instr;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, cpsr_q, spsr_q;
  logic        rf_wr_en, done, err;

  logic [31:0] regs [16];
  assign rf_rd_data = regs[rf_rd_idx];

  psr_xfer_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .target_saved(target_saved), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .cpsr_q(cpsr_q), .spsr_q(spsr_q), .done(done), .err(err)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_cpsr;
  logic [31:0] m_spsr [5];

  localparam logic [4:0] MODES [5] = '{5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bidx(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] rot_imm(input logic [7:0] imm, input logic [3:0] r);
    logic [31:0] v;
    int a;
    v = {24'h0, imm};
    a = 2 * int'(r);
    if (a == 0) return v;
    return (v >> a) | (v << (32 - a));
  endfunction

  function automatic logic [31:0] i_read(input logic [3:0] rd);
    return (32'h1 << 19) | (32'(rd) << 12);
  endfunction
  function automatic logic [31:0] i_full(input logic [3:0] rm);
    return (32'h5 << 19) | 32'(rm);
  endfunction
  function automatic logic [31:0] i_flags(input logic [3:0] rm);
    return (32'h5 << 19) | (32'h1 << 16) | 32'(rm);
  endfunction
  function automatic logic [31:0] i_fimm(input logic [3:0] r, input logic [7:0] imm);
    return (32'h1 << 25) | (32'h5 << 19) | (32'h1 << 16) | (32'(r) << 8) | 32'(imm);
  endfunction

  function automatic logic [31:0] view_spsr(input logic [31:0] c);
    int b;
    b = bidx(c[4:0]);
    return (b < 0) ? 32'h0 : m_spsr[b];
  endfunction

  // Drive one strobe at a falling edge and check its results one edge later.
  task automatic op(input logic [31:0] ins, input logic sv, input string req);
    logic [2:0] cls, sub;
    int b;
    logic e_err, e_we;
    logic [3:0] e_idx;
    logic [31:0] e_data, n_cpsr, src, opnd, old, nv;
    logic [31:0] n_spsr [5];
    cls = ins[21:19];
    sub = ins[18:16];
    b = bidx(m_cpsr[4:0]);
    e_err = 1'b0; e_we = 1'b0; e_idx = '0; e_data = '0;
    n_cpsr = m_cpsr;
    for (int k = 0; k < 5; k++) n_spsr[k] = m_spsr[k];
    if (cls == 3'b001) begin
      if (sv && b < 0) e_err = 1'b1;
      else begin
        e_we = 1'b1; e_idx = ins[15:12];
        e_data = sv ? m_spsr[b] : m_cpsr;
      end
    end else if (cls == 3'b101 && (sub == 3'b000 || sub == 3'b001)) begin
      if (sv && b < 0) e_err = 1'b1;
      else begin
        src  = regs[ins[3:0]];
        opnd = ins[25] ? rot_imm(ins[7:0], ins[11:8]) : src;
        old  = sv ? m_spsr[b] : m_cpsr;
        if (sub == 3'b000)
          nv = (!sv && m_cpsr[4:0] == 5'b10000) ? {src[31:28], old[27:0]} : src;
        else
          nv = {opnd[31:28], old[27:0]};
        if (sv) n_spsr[b] = nv; else n_cpsr = nv;
      end
    end else e_err = 1'b1;

    instr = ins; target_saved = sv; in_valid = 1'b1;
    @(negedge clk);
    chk(req, "done", 32'(done), 32'h1);
    chk(req, "err", 32'(err), 32'(e_err));
    chk(req, "rf_wr_en", 32'(rf_wr_en), 32'(e_we));
    if (e_we) begin
      chk(req, "rf_wr_idx", 32'(rf_wr_idx), 32'(e_idx));
      chk(req, "rf_wr_data", rf_wr_data, e_data);
    end
    m_cpsr = n_cpsr;
    for (int k = 0; k < 5; k++) m_spsr[k] = n_spsr[k];
    if (e_we) regs[e_idx] = e_data;
    chk(req, "cpsr", cpsr_q, m_cpsr);
    chk({req, "/R11"}, "spsr", spsr_q, view_spsr(m_cpsr));
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "done idle", 32'(done), 32'h0);
    chk("R10", "err idle", 32'(err), 32'h0);
    chk("R10", "wr_en idle", 32'(rf_wr_en), 32'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; instr = '0; target_saved = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_cpsr = 32'h0000_00D3;
    for (int k = 0; k < 5; k++) m_spsr[k] = '0;
    chk("R1", "cpsr reset", cpsr_q, 32'h0000_00D3);
    chk("R1", "spsr reset", spsr_q, 32'h0);
    chk("R1", "done reset", 32'(done), 32'h0);
    chk("R1", "err reset", 32'(err), 32'h0);
    chk("R1", "wr_en reset", 32'(rf_wr_en), 32'h0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++)
      regs[i] = (32'h1357_9BDF << i) ^ (32'hE468_ACE0 >> i) ^ 32'(i);
    do_reset();

    // R3: read the current word into every register index.
    for (int i = 0; i < 16; i++) op(i_read(4'(i)), 1'b0, "R3");
    idle();

    // R6 / R5: rotated immediates, all rotate amounts.
    for (int r = 0; r < 16; r++) begin
      op(i_fimm(4'(r), 8'h0F), 1'b0, "R6");
      op(i_fimm(4'(r), 8'hA5), 1'b0, "R6");
      op(i_fimm(4'(r), 8'hF0), 1'b0, "R6");
      op(i_fimm(4'(r), 8'h81), 1'b0, "R6");
    end
    for (int i = 0; i < 16; i++) op(i_flags(4'(i)), 1'b0, "R5");

    // R4 / R7: each privileged mode, mode switch then immediate saved access.
    for (int m = 0; m < 5; m++) begin
      regs[1] = {4'b1010, 20'h0, 3'b110, MODES[m]};
      op(i_full(4'd1), 1'b0, "R4");
      regs[2] = 32'h0F0F_0000 ^ (32'h1111_1111 * 32'(m + 1)) ^ 32'(MODES[m]);
      op(i_full(4'd2), 1'b1, "R7");
      op(i_fimm(4'(m + 1), 8'hC3), 1'b1, "R5");
      op(i_read(4'd3), 1'b1, "R7");
    end
    // R7: banks stay separate.
    for (int m = 0; m < 5; m++) begin
      regs[1] = {4'b0101, 20'h0, 3'b110, MODES[m]};
      op(i_full(4'd1), 1'b0, "R7");
      op(i_read(4'd4), 1'b1, "R7");
    end

    // R2: decode sweep over class and sub-field, both targets.
    for (int f = 0; f < 8; f++)
      for (int s = 0; s < 8; s++) begin
        op((32'(f) << 19) | (32'(s) << 16) | (32'h9 << 12) | 32'h2, 1'b0, "R2");
        op((32'(f) << 19) | (32'(s) << 16) | (32'h8 << 12) | 32'h2, 1'b1, "R2");
      end
    idle();

    // R9: system mode has no bank.
    regs[1] = {4'b0000, 20'h0, 3'b110, 5'b11111};
    op(i_full(4'd1), 1'b0, "R4");
    op(i_read(4'd5), 1'b1, "R9");
    op(i_full(4'd2), 1'b1, "R9");

    // R8: user mode only reaches the flags.
    regs[1] = {4'b0000, 20'h0, 3'b110, 5'b10000};
    op(i_full(4'd1), 1'b0, "R4");
    regs[6] = 32'h5FFF_FF1F;
    op(i_full(4'd6), 1'b0, "R8");
    regs[6] = 32'hA000_0011;
    op(i_full(4'd6), 1'b0, "R8");
    op(i_fimm(4'd2, 8'h0B), 1'b0, "R5");
    op(i_read(4'd7), 1'b1, "R9");
    op(i_full(4'd6), 1'b1, "R9");
    op(i_read(4'd8), 1'b0, "R3");
    idle();

    summary();
    $finish;
  end

endmodule